// File: doc/BRIEF.md
# Light-Load Pulse-Skip Mode Controller

This block holds the digital mode logic of a current-mode synchronous step-down converter. The analog loop is outside the block. It reaches the block only as comparator flags: zero crossing of the low-side current, the skip-level and regulation-level current trips, overcurrent, and three output-window flags at +1.5 %, nominal and −1.5 %. A per-cycle tick from the switching oscillator marks the start of every switching period. From these inputs the block drives the high-side and low-side switch enables, one fast system clock at a time.

The block runs in fixed-frequency PWM. When automatic mode is allowed, it moves into a light-load pulse-skip mode once the inductor current has crossed zero in a run of consecutive cycles. In skip mode each pulse is still started by the tick and ends at a low current level. The low-side switch opens at the zero crossing. The output window then decides whether pulsing stops, resumes, or hands control back to PWM. A dropout input allows full duty. In every other case the on-time is capped. Overcurrent always ends the high-side pulse.

Top module: `skip_mode_ctrl`

## Requirements
- R1: In PWM mode, a tick starts a high-side pulse. The pulse ends when `pwm_trip` is sampled, and the low-side switch then stays on until the next tick. With a trip sampled T clocks after the tick, in steady state the high side is on for T−1 clocks and the low side for PERIOD_CLKS−T−1 clocks of each period.
- R2: `hs_en` and `ls_en` are never high together. Whenever one of them hands over to the other, there is at least one system clock with both low.
- R3: Skip mode (`skip_active`=1) is entered at the tick that follows ZC_RUN (default 8) consecutive switching cycles in which `zero_cross` was seen while the low side was on. Entry never happens without `auto_skip`=1.
- R4: A cycle with no zero crossing restarts the consecutive-cycle count from zero.
- R5: In skip mode, each pulse starts on the tick and ends when `skip_trip` is sampled. The low side opens when `zero_cross` is sampled, and both switches stay off until the next tick. With trip T and zero crossing at clock 17, the high side is on for T clocks and the low side for 8 clocks per period.
- R6: In skip mode, `out_above` ends the high-side pulse at once, and pulsing halts. While the output stays at or above nominal (`out_below_nom`=0), a tick starts no pulse.
- R7: After a halt, the first tick with `out_below_nom`=1 starts a new pulse.
- R8: A tick in skip mode with `out_low`=1 returns the block to PWM. The low side then stays on through zero crossings again.
- R9: With `auto_skip`=0 the block never enters skip mode. If the block is in skip mode, a tick with `auto_skip`=0 returns it to PWM and clears the run count.
- R10: Without `dropout`, the high-side on-time is capped at MAX_ON = PERIOD_CLKS·90/100 clocks. With the default of 20 clocks per period and no trip, it is on for 17 clocks. With `dropout`=1 the high side stays on for the whole period.
- R11: `oc_trip` ends the high-side pulse in any mode, dropout included. `hs_en` is low from the second clock edge after the flag is sampled.
- R12: While `rst` is high, both enables and `skip_active` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_tick | input | 1 | One-clock pulse at the start of each switching period |
| auto_skip | input | 1 | 1: automatic skip allowed, 0: forced PWM |
| dropout | input | 1 | Allow 100 % high-side duty |
| zero_cross | input | 1 | Low-side current crossed zero |
| skip_trip | input | 1 | Sensed current reached the skip pulse level |
| pwm_trip | input | 1 | Sensed current reached the regulation threshold |
| oc_trip | input | 1 | Overcurrent |
| out_above | input | 1 | Output above nominal +1.5 % |
| out_below_nom | input | 1 | Output below nominal |
| out_low | input | 1 | Output below nominal −1.5 % |
| hs_en | output | 1 | High-side switch enable |
| ls_en | output | 1 | Low-side switch enable |
| skip_active | output | 1 | 1 while in pulse-skip mode |

## Verification
Two functions can act on the high side in the same cycle: the dropout path, which holds the high side on for the full period, and the overcurrent trip, which must end that pulse. The bench raises `oc_trip` partway through a cycle while `dropout` is high. It then requires the high-side count for that period to stop at the computed clock, with the low side following after one dead clock. A second clash comes from the zero-crossing run and the mode pin. The bench replays a table in which a forced-PWM tick lands while skip mode is active, and a run broken by one quiet cycle restarts the count. The mode flag must change at exactly the tick the requirements predict.

// File: rtl/skip_pkg.sv
package skip_pkg;

    typedef enum logic [1:0] {
        PH_OFF = 2'd0,
        PH_HS  = 2'd1,
        PH_LS  = 2'd2
    } phase_t;

    typedef enum logic {
        MD_PWM  = 1'b0,
        MD_SKIP = 1'b1
    } mode_t;

    typedef struct packed {
        logic zc;
        logic skip_trip;
        logic pwm_trip;
        logic oc;
        logic above;
        logic below_nom;
        logic low;
    } sense_t;

    function automatic int unsigned max_on_clks(input int unsigned period, input int unsigned pct);
        return (period * pct) / 100;
    endfunction

endpackage

// File: rtl/zc_run_counter.sv
module zc_run_counter #(
    parameter int unsigned ZC_RUN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic clear,
    input  logic seen,
    output logic run_done
);
    localparam int unsigned CW = $clog2(ZC_RUN + 1);
    localparam logic [CW-1:0] LAST = CW'(ZC_RUN - 1);

    logic [CW-1:0] cnt;

    // the run is complete when this cycle's crossing is number ZC_RUN
    assign run_done = seen && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (tick) begin
            if (clear || !seen)
                cnt <= '0;
            else if (cnt != LAST)
                cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    assert_quiet_clears_R4: assert property (@(posedge clk) disable iff (rst)
        tick && !seen |=> cnt == '0);

endmodule

// File: rtl/cycle_fsm.sv
module cycle_fsm
    import skip_pkg::*;
#(
    parameter int unsigned PERIOD_CLKS = 20,
    parameter int unsigned DUTY_PCT    = 90
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    input  logic   auto_skip,
    input  logic   dropout,
    input  sense_t sns,
    input  logic   run_done,
    output logic   zc_seen,
    output mode_t  mode,
    output phase_t phase
);
    localparam int unsigned MAX_ON = max_on_clks(PERIOD_CLKS, DUTY_PCT);
    localparam int unsigned OW     = $clog2(PERIOD_CLKS + 1);
    localparam logic [OW-1:0] ON_LAST = OW'(MAX_ON - 1);

    logic [OW-1:0] on_cnt;
    logic          halted;
    logic          on_cap;
    logic          hs_exit;

    assign on_cap  = (on_cnt >= ON_LAST) && !dropout;
    assign hs_exit = sns.oc || on_cap ||
                     ((mode == MD_SKIP) ? (sns.skip_trip || sns.above) : sns.pwm_trip);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MD_PWM;
            phase   <= PH_OFF;
            on_cnt  <= '0;
            halted  <= 1'b0;
            zc_seen <= 1'b0;
        end else if (tick) begin
            zc_seen <= 1'b0;
            on_cnt  <= '0;
            if (mode == MD_PWM) begin
                phase  <= PH_HS;
                halted <= 1'b0;
                if (auto_skip && run_done)
                    mode <= MD_SKIP;
            end else if (!auto_skip || sns.low) begin
                mode   <= MD_PWM;
                phase  <= PH_HS;
                halted <= 1'b0;
            end else if (sns.above || (halted && !sns.below_nom)) begin
                halted <= 1'b1;
                if (phase == PH_HS)
                    phase <= PH_LS;
            end else begin
                phase  <= PH_HS;
                halted <= 1'b0;
            end
        end else begin
            if (phase == PH_HS) begin
                if (on_cnt != OW'(PERIOD_CLKS))
                    on_cnt <= on_cnt + 1'b1;
                if (hs_exit)
                    phase <= PH_LS;
            end
            if (mode == MD_SKIP && sns.above)
                halted <= 1'b1;
            if (phase == PH_LS && sns.zc) begin
                if (mode == MD_SKIP)
                    phase <= PH_OFF;
                else
                    zc_seen <= 1'b1;
            end
        end
    end

    assert_forced_pwm_R9: assert property (@(posedge clk) disable iff (rst)
        tick && !auto_skip |=> mode == MD_PWM);

    assert_oc_ends_pulse_R11: assert property (@(posedge clk) disable iff (rst)
        sns.oc && !tick |=> phase != PH_HS);

    assert_halt_no_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        halted |-> phase != PH_HS);

    assert_low_exits_R8: assert property (@(posedge clk) disable iff (rst)
        tick && sns.low && mode == MD_SKIP |=> mode == MD_PWM);

    assert_pwm_no_idle_R1: assert property (@(posedge clk) disable iff (rst)
        mode == MD_PWM && phase == PH_LS && !tick |=> phase != PH_OFF);

endmodule

// File: rtl/gate_driver.sv
module gate_driver (
    input  logic clk,
    input  logic rst,
    input  logic want_hs,
    input  logic want_ls,
    output logic hs_q,
    output logic ls_q
);
    // a switch closes only once the other is seen open: one dead clock
    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= 1'b0;
            ls_q <= 1'b0;
        end else begin
            hs_q <= want_hs && !ls_q;
            ls_q <= want_ls && !hs_q;
        end
    end

    assert_dead_ls_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(ls_q) |-> !$past(hs_q));

endmodule

// File: rtl/skip_mode_ctrl.sv
module skip_mode_ctrl
    import skip_pkg::*;
#(
    parameter int unsigned PERIOD_CLKS = 20,
    parameter int unsigned DUTY_PCT    = 90,
    parameter int unsigned ZC_RUN      = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic cyc_tick,
    input  logic auto_skip,
    input  logic dropout,
    input  logic zero_cross,
    input  logic skip_trip,
    input  logic pwm_trip,
    input  logic oc_trip,
    input  logic out_above,
    input  logic out_below_nom,
    input  logic out_low,
    output logic hs_en,
    output logic ls_en,
    output logic skip_active
);
    localparam int unsigned MAX_ON = max_on_clks(PERIOD_CLKS, DUTY_PCT);
    localparam int unsigned LW     = $clog2(PERIOD_CLKS + 2);

    sense_t sns;
    mode_t  mode;
    phase_t phase;
    logic   zc_seen;
    logic   run_done;

    assign sns = '{zc: zero_cross, skip_trip: skip_trip, pwm_trip: pwm_trip,
                   oc: oc_trip, above: out_above, below_nom: out_below_nom,
                   low: out_low};

    zc_run_counter #(.ZC_RUN(ZC_RUN)) u_run (
        .clk      (clk),
        .rst      (rst),
        .tick     (cyc_tick),
        .clear    ((mode == MD_SKIP) || !auto_skip),
        .seen     (zc_seen),
        .run_done (run_done)
    );

    cycle_fsm #(.PERIOD_CLKS(PERIOD_CLKS), .DUTY_PCT(DUTY_PCT)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (cyc_tick),
        .auto_skip (auto_skip),
        .dropout   (dropout),
        .sns       (sns),
        .run_done  (run_done),
        .zc_seen   (zc_seen),
        .mode      (mode),
        .phase     (phase)
    );

    gate_driver u_drv (
        .clk     (clk),
        .rst     (rst),
        .want_hs (phase == PH_HS),
        .want_ls (phase == PH_LS),
        .hs_q    (hs_en),
        .ls_q    (ls_en)
    );

    assign skip_active = (mode == MD_SKIP);

    // checker state: length of the current high-side run outside dropout
    logic [LW-1:0] hs_len;
    always_ff @(posedge clk) begin
        if (rst || !hs_en || dropout)
            hs_len <= '0;
        else if (hs_len != LW'(PERIOD_CLKS + 1))
            hs_len <= hs_len + 1'b1;
    end

    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (rst)
        !(hs_en && ls_en));

    assert_dead_hs_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_en) |-> !$past(ls_en));

    assert_entry_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(skip_active) |-> $past(cyc_tick) && $past(auto_skip));

    assert_max_on_R10: assert property (@(posedge clk) disable iff (rst)
        hs_len <= LW'(MAX_ON));

    assert_oc_port_R11: assert property (@(posedge clk) disable iff (rst)
        oc_trip && !cyc_tick |-> ##2 !hs_en);

endmodule

// File: tb/sim_skip_mode_ctrl.sv
module sim_skip_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int P = 20;
    localparam int NVEC = 31;
    // {auto_skip, zero crossing this cycle, expected skip_active after this cycle's tick}
    localparam logic [2:0] VEC [0:NVEC-1] = '{
        3'b110, 3'b110, 3'b110, 3'b110, 3'b110,
        3'b100,
        3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110, 3'b110,
        3'b101, 3'b101,
        3'b000,
        3'b010, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010,
        3'b110, 3'b110, 3'b110, 3'b110, 3'b110
    };

    logic clk = 1'b0;
    logic rst, cyc_tick, auto_skip, dropout, zero_cross, skip_trip, pwm_trip;
    logic oc_trip, out_above, out_below_nom, out_low;
    logic hs_en, ls_en, skip_active;

    int n_tests = 0, n_fail = 0, viol = 0;
    logic prev_hs = 1'b0, prev_ls = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    skip_mode_ctrl u0 (
        .clk(clk), .rst(rst), .cyc_tick(cyc_tick), .auto_skip(auto_skip),
        .dropout(dropout), .zero_cross(zero_cross), .skip_trip(skip_trip),
        .pwm_trip(pwm_trip), .oc_trip(oc_trip), .out_above(out_above),
        .out_below_nom(out_below_nom), .out_low(out_low),
        .hs_en(hs_en), .ls_en(ls_en), .skip_active(skip_active)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one switching period; counts enable clocks in the window
    task automatic cyc(input int trip_at, input int oc_at, input int hi_at, input bit zc,
                       output int hs_c, output int ls_c, output int md);
        hs_c = 0; ls_c = 0; md = 0;
        for (int k = 0; k < P; k++) begin
            @(negedge clk);
            hs_c += int'(hs_en);
            ls_c += int'(ls_en);
            if (k == 1) md = int'(skip_active);
            if (hs_en && ls_en) viol++;
            if (hs_en && !prev_hs && prev_ls) viol++;
            if (ls_en && !prev_ls && prev_hs) viol++;
            prev_hs = hs_en; prev_ls = ls_en;
            cyc_tick   = (k == 0);
            pwm_trip   = (k == trip_at);
            skip_trip  = (k == trip_at);
            oc_trip    = (k == oc_at);
            out_above  = (k == hi_at);
            zero_cross = zc && (k == P - 3);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1 (run completed)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int h, l, m;
        rst = 1'b1; cyc_tick = 0; auto_skip = 0; dropout = 0; zero_cross = 0;
        skip_trip = 0; pwm_trip = 0; oc_trip = 0; out_above = 0;
        out_below_nom = 0; out_low = 0;
        repeat (3) @(negedge clk);
        check("R12 hs_en in reset", int'(hs_en), 0);
        check("R12 ls_en in reset", int'(ls_en), 0);
        check("R12 skip_active in reset", int'(skip_active), 0);
        rst = 1'b0;

        // R1 PWM timing
        cyc(8, -1, -1, 0, h, l, m);
        cyc(8, -1, -1, 0, h, l, m);
        check("R1 hs clocks trip 8", h, 7);
        check("R1 ls clocks trip 8", l, 11);
        cyc(4, -1, -1, 0, h, l, m);
        check("R1 hs clocks trip 4", h, 3);
        check("R1 ls clocks trip 4", l, 15);

        // R10 on-time cap and dropout
        cyc(-1, -1, -1, 0, h, l, m);
        check("R10 capped hs first", h, 17);
        cyc(-1, -1, -1, 0, h, l, m);
        check("R10 capped hs", h, 17);
        check("R10 capped ls", l, 1);
        dropout = 1;
        cyc(-1, -1, -1, 0, h, l, m);
        cyc(-1, -1, -1, 0, h, l, m);
        check("R10 dropout hs full", h, 20);
        check("R10 dropout ls none", l, 0);

        // R11 overcurrent during dropout
        cyc(-1, 5, -1, 0, h, l, m);
        check("R11 oc hs clocks", h, 7);
        check("R11 oc ls clocks", l, 12);
        dropout = 0;
        cyc(8, -1, -1, 0, h, l, m);

        // R3 R4 R9 table of zero-crossing runs and mode pin
        for (int i = 0; i < NVEC; i++) begin
            auto_skip = VEC[i][2];
            cyc(8, -1, -1, VEC[i][1], h, l, m);
            check($sformatf("R3 R4 R9 row %0d skip_active", i), m, int'(VEC[i][0]));
        end

        // R3 entry after exactly eight crossings
        auto_skip = 1;
        cyc(8, -1, -1, 0, h, l, m);
        cyc(8, -1, -1, 0, h, l, m);
        for (int i = 0; i < 8; i++) begin
            cyc(8, -1, -1, 1, h, l, m);
            check("R3 no entry during run", m, 0);
        end
        cyc(8, -1, -1, 1, h, l, m);
        check("R3 entry after run", m, 1);

        // R5 skip pulse shape
        cyc(8, -1, -1, 1, h, l, m);
        check("R5 skip hs clocks", h, 8);
        check("R5 skip ls clocks", l, 8);

        // R6 stop at +1.5 %
        cyc(-1, -1, 4, 1, h, l, m);
        check("R6 hs cut by out_above", h, 4);
        check("R6 ls after cut", l, 12);
        cyc(8, -1, -1, 1, h, l, m);
        check("R6 halted hs", h, 0);
        check("R6 halted ls", l, 0);
        check("R6 still skip", m, 1);

        // R7 resume below nominal
        out_below_nom = 1;
        cyc(8, -1, -1, 1, h, l, m);
        check("R7 resumed hs", h, 8);
        check("R7 resumed ls", l, 8);
        out_below_nom = 0;

        // R8 exit at -1.5 %
        out_low = 1;
        cyc(8, -1, -1, 1, h, l, m);
        check("R8 exit to pwm", m, 0);
        out_low = 0;
        cyc(8, -1, -1, 1, h, l, m);
        check("R8 pwm hs", h, 7);
        check("R8 pwm ls through crossing", l, 11);

        check("R2 overlap or dead-time violations", viol, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule